// File: doc/BRIEF.md
# Setup/Hold Violation Checker for Oversampled Channels

This block watches a group of oversampled data channels and one oversampled reference clock channel. Every core cycle it receives one word of eight consecutive fine samples per channel, where one fine sample is the unit of time. It keeps a short sample history for each channel. It finds the level changes on all channels, shifts each data channel by its own signed skew correction, and checks whether any data change lands inside a window around the active reference edge. The setup and hold values set the two sides of that window separately.

When a data change lands inside the window, the block raises a violation flag for one cycle. At the same time it reports the channel number and the signed distance, in fine samples, from the reference edge to the data change. The flag can drive an acquisition trigger directly.

The history is long enough that data changes after a reference edge are judged against that edge. This includes the full hold side and the largest skew correction. A reference edge is therefore judged a fixed number of words after it arrives.

Top module: `shv_monitor`

## Requirements
- R1: Each cycle, data channel c presents its word on `dat_i[c*8 +: 8]` and the reference presents its word on `ref_i`. Bit j of a word is sample j, and bit 0 is the earliest sample. Word n after reset holds global sample indices 8n to 8n+7.
- R2: An edge or a change is timed at the first sample that has the new level. With `edge_rise_i`=1 the active reference edge is a 0-to-1 step. With `edge_rise_i`=0 it is a 1-to-0 step.
- R3: A data change at raw sample index r on channel c is judged at the corrected time T = r - k. Here k is the two's complement value in `skew_i[c*5 +: 5]`, limited to the range -8 to +8: larger values act as +8 and smaller values act as -8.
- R4: A data change violates against an active edge at time E when -setup <= T-E < hold. Both setup and hold are unsigned values from 0 to 31.
- R5: During a violation cycle, `viol_o`=1, `viol_ch_o` gives the channel number and `viol_off_o` gives T-E as a 7-bit two's complement value. In every other cycle all three outputs are 0.
- R6: A reference edge at global index s is judged with word m = floor((s+38)/8). Its result appears on the outputs after the clock edge that follows the capture of word m. Each edge is judged exactly once.
- R7: When several violations are judged in the same cycle, the lowest channel number wins. Within that channel the earliest reference edge wins, and then the earliest data change wins.
- R8: Data changes outside the window produce no report. Reference steps of the inactive polarity produce no report.
- R9: A synchronous active-low reset clears the outputs and every sample history. Samples before the first word after reset count as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one sample word per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| dat_i | input | NCH*8 | Data channel sample words, channel c at bits c*8 +: 8 |
| ref_i | input | 8 | Reference clock sample word |
| skew_i | input | NCH*5 | Signed skew correction per channel, channel c at bits c*5 +: 5 |
| setup_i | input | 5 | Setup side of the window in samples |
| hold_i | input | 5 | Hold side of the window in samples |
| edge_rise_i | input | 1 | 1 selects rising reference edges, 0 selects falling |
| viol_o | output | 1 | Violation flag, usable as an acquisition trigger |
| viol_ch_o | output | 2 | Channel number of the reported violation |
| viol_off_o | output | 7 | Signed distance from the edge to the data change, in samples |

## Verification
The assertions check, on every cycle, several local properties:
- the bit order and age order of the sample histories;
- that a per-channel hit only occurs when an active reference edge is present;
- that every reported offset lies inside the setup and hold window in force;
- that the outputs are zero when idle;
- that the outputs are clear after reset.

Only the bench scenarios can show the parts that depend on exact timing. These are:
- whether the window is correct at both its boundaries;
- whether the skew shift is applied and limited correctly;
- which word judges a given edge;
- how ties between channels, edges and data changes are ordered.

The bench compares every output cycle against a model written in absolute sample time.

// File: rtl/shv_pkg.sv
`timescale 1ns/1ps
// shv_pkg: helpers shared by the setup/hold checker modules.
// Assumes nothing beyond integer arithmetic.
package shv_pkg;

    // Limit a signed value to the symmetric range [-lim, +lim].
    function automatic int clamp_sym(int v, int lim);
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

endpackage

// File: rtl/shv_history.sv
`timescale 1ns/1ps
// shv_history: age-ordered sample history of one oversampled channel.
// Bit a of hist_o holds the sample that is a samples old. Age 0 is the
// newest sample of the newest word. Assumes bit 0 of word_i is the
// earliest sample of the word and that N >= 2*SPW.
module shv_history #(
    parameter int SPW = 8,
    parameter int N   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SPW-1:0] word_i,
    output logic [N-1:0]   hist_o
);

    logic [SPW-1:0] rev;

    // Reverse the word so that the latest sample lands at age 0.
    always_comb begin
        for (int j = 0; j < SPW; j++) begin
            rev[j] = word_i[SPW-1-j];
        end
    end

    // Age every held sample by one word and insert the new word.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_o <= '0;
        else        hist_o <= {hist_o[N-SPW-1:0], rev};
    end

    // R1: earliest sample of the last word sits at age SPW-1.
    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hist_o[SPW-1] == $past(word_i[0]));

    // R1: each word ages by exactly one word per cycle.
    p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> hist_o[2*SPW-1:SPW] == $past(hist_o[SPW-1:0]));

endmodule

// File: rtl/shv_align.sv
`timescale 1ns/1ps
// shv_align: finds the level changes of one data channel and places
// them on the skew-corrected age axis. Bit i of trans_o marks a change
// whose first new-level sample has corrected age T_LO+i. The history must
// cover raw ages up to T_LO+T_N+SKEW_MAX.
module shv_align
    import shv_pkg::*;
#(
    parameter int N        = 86,
    parameter int SKEW_MAX = 8,
    parameter int SKW_W    = 5,
    parameter int T_LO     = 8,
    parameter int T_N      = 69
) (
    input  logic [N-1:0]            hist_i,
    input  logic signed [SKW_W-1:0] skew_i,
    output logic [T_N-1:0]          trans_o
);

    localparam int AW = $clog2(N);

    int sk;

    // Limit the programmed skew to the supported range.
    always_comb sk = clamp_sym(int'(skew_i), SKEW_MAX);

    // A change sits at corrected age t when raw ages t-sk and t-sk+1 differ.
    always_comb begin
        for (int i = 0; i < T_N; i++) begin
            trans_o[i] = hist_i[AW'(T_LO + i - sk)] ^ hist_i[AW'(T_LO + i - sk + 1)];
        end
    end

endmodule

// File: rtl/shv_window.sv
`timescale 1ns/1ps
// shv_window: compares the corrected changes of one channel with the
// reference edges judged this cycle. Bit k of edge_i is an edge at age
// BASE+k. A change at age t violates when -setup <= e-t < hold. The
// preference goes to the oldest edge first and then to the oldest change.
module shv_window #(
    parameter int SPW     = 8,
    parameter int BASE    = 38,
    parameter int T_LO    = 8,
    parameter int T_N     = 69,
    parameter int WIN_MAX = 31,
    parameter int WIN_W   = 5,
    parameter int OFF_W   = 7
) (
    input  logic [T_N-1:0]          trans_i,
    input  logic [SPW-1:0]          edge_i,
    input  logic [WIN_W-1:0]        setup_i,
    input  logic [WIN_W-1:0]        hold_i,
    output logic                    hit_o,
    output logic signed [OFF_W-1:0] off_o
);

    localparam int IW = $clog2(T_N);

    // Scan the edges oldest first and, for each, its offsets from most negative.
    always_comb begin
        hit_o = 1'b0;
        off_o = '0;
        for (int k = SPW-1; k >= 0; k--) begin
            if (edge_i[k] && !hit_o) begin
                for (int d = -WIN_MAX; d < WIN_MAX; d++) begin
                    if (!hit_o && d >= -int'(setup_i) && d < int'(hold_i)
                        && trans_i[IW'(BASE + k - d - T_LO)]) begin
                        hit_o = 1'b1;
                        off_o = OFF_W'(d);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/shv_monitor.sv
`timescale 1ns/1ps
// shv_monitor: setup/hold violation checker for NCH oversampled data
// channels against one oversampled reference clock. Reference edges are
// judged at a fixed age, so that hold-side changes and skew shifts are
// already present in the history. The result is registered. The lowest
// channel wins. Assumes one word of SPW samples per channel per cycle.
module shv_monitor #(
    parameter  int NCH      = 4,
    parameter  int SPW      = 8,
    parameter  int SKEW_MAX = 8,
    parameter  int WIN_MAX  = 31,
    localparam int SKW_W    = $clog2(SKEW_MAX + 1) + 1,
    localparam int WIN_W    = $clog2(WIN_MAX + 1),
    localparam int OFF_W    = WIN_W + 2,
    localparam int CH_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH*SPW-1:0]      dat_i,
    input  logic [SPW-1:0]          ref_i,
    input  logic [NCH*SKW_W-1:0]    skew_i,
    input  logic [WIN_W-1:0]        setup_i,
    input  logic [WIN_W-1:0]        hold_i,
    input  logic                    edge_rise_i,
    output logic                    viol_o,
    output logic [CH_W-1:0]         viol_ch_o,
    output logic signed [OFF_W-1:0] viol_off_o
);

    // Youngest edge age judged: the hold side plus the skew reach are in history.
    localparam int BASE  = WIN_MAX + SKEW_MAX - 1;
    localparam int T_LO  = SKEW_MAX;
    localparam int T_HI  = BASE + SPW - 1 + WIN_MAX;
    localparam int T_N   = T_HI - T_LO + 1;
    localparam int N_DAT = T_HI + SKEW_MAX + 2;
    localparam int N_REF = BASE + SPW + 1;

    logic [N_REF-1:0]       ref_hist;
    logic [SPW-1:0]         edge_vec;
    logic [NCH-1:0]         hit;
    logic signed [OFF_W-1:0] off_c [NCH];
    logic                    pick_v;
    logic [CH_W-1:0]         pick_ch;
    logic signed [OFF_W-1:0] pick_off;

    shv_history #(.SPW(SPW), .N(N_REF)) u_ref_hist (
        .clk(clk), .rst_n(rst_n), .word_i(ref_i), .hist_o(ref_hist)
    );

    // Active edges at ages BASE..BASE+SPW-1: new level at age e, old at e+1.
    for (genvar k = 0; k < SPW; k++) begin : g_edge
        assign edge_vec[k] = (ref_hist[BASE+k] == edge_rise_i)
                           && (ref_hist[BASE+k+1] != edge_rise_i);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [N_DAT-1:0] hist;
        logic [T_N-1:0]   trans;

        shv_history #(.SPW(SPW), .N(N_DAT)) u_hist (
            .clk(clk), .rst_n(rst_n), .word_i(dat_i[c*SPW +: SPW]), .hist_o(hist)
        );

        shv_align #(
            .N(N_DAT), .SKEW_MAX(SKEW_MAX), .SKW_W(SKW_W), .T_LO(T_LO), .T_N(T_N)
        ) u_align (
            .hist_i(hist), .skew_i(skew_i[c*SKW_W +: SKW_W]), .trans_o(trans)
        );

        shv_window #(
            .SPW(SPW), .BASE(BASE), .T_LO(T_LO), .T_N(T_N),
            .WIN_MAX(WIN_MAX), .WIN_W(WIN_W), .OFF_W(OFF_W)
        ) u_win (
            .trans_i(trans), .edge_i(edge_vec), .setup_i(setup_i), .hold_i(hold_i),
            .hit_o(hit[c]), .off_o(off_c[c])
        );
    end

    // Lowest-numbered violating channel wins.
    always_comb begin
        pick_v   = 1'b0;
        pick_ch  = '0;
        pick_off = '0;
        for (int c = NCH-1; c >= 0; c--) begin
            if (hit[c]) begin
                pick_v   = 1'b1;
                pick_ch  = CH_W'(c);
                pick_off = off_c[c];
            end
        end
    end

    // Register the report; all fields read zero when there is no violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o     <= 1'b0;
            viol_ch_o  <= '0;
            viol_off_o <= '0;
        end else begin
            viol_o     <= pick_v;
            viol_ch_o  <= pick_ch;
            viol_off_o <= pick_off;
        end
    end

    // R2: a channel can only hit while an active reference edge is judged.
    p_hit_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |-> (|edge_vec));

    // R4: a reported offset lies inside the window that was in force.
    p_off_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (int'(viol_off_o) >= -int'($past(setup_i)))
                && (int'(viol_off_o) < int'($past(hold_i))));

    // R5: idle outputs read zero.
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_o |-> (viol_ch_o == '0) && (viol_off_o == '0));

    // R9: the first cycle after reset shows no violation.
    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !viol_o);

endmodule

// File: tb/shv_monitor_tb_top.sv
`timescale 1ns/1ps
// Directed bench for shv_monitor. Each scenario loads sample streams
// into arrays and then compares every output cycle against a model that
// works in absolute sample time.
module shv_monitor_tb_top;

    localparam int NCH = 4;
    localparam int SPW = 8;
    localparam int NWR = 56;
    localparam int NS  = NWR * SPW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*SPW-1:0] dat = '0;
    logic [SPW-1:0]     refw = '0;
    logic [NCH*5-1:0]   skew = '0;
    logic [4:0]         setup = '0;
    logic [4:0]         hold = '0;
    logic               rise = 1'b1;
    logic               v;
    logic [1:0]         ch;
    logic signed [6:0]  off;

    bit dm [NCH][NS];
    bit rm [NS];
    int skm [NCH];
    int sum, hom;
    bit polm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    shv_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .dat_i(dat), .ref_i(refw), .skew_i(skew),
        .setup_i(setup), .hold_i(hold), .edge_rise_i(rise),
        .viol_o(v), .viol_ch_o(ch), .viol_off_o(off)
    );

    function automatic bit gd(int c, int i);
        if (i < 0 || i >= NS) return 1'b0;
        return dm[c][i];
    endfunction

    function automatic bit gr(int i);
        if (i < 0 || i >= NS) return 1'b0;
        return rm[i];
    endfunction

    function automatic int clampi(int x);
        if (x > 8)  return 8;
        if (x < -8) return -8;
        return x;
    endfunction

    // Expected report for word n (R2, R3, R4, R6, R7).
    task automatic model(input int n, output bit ev, output int ec, output int eo);
        ev = 1'b0; ec = 0; eo = 0;
        for (int c = 0; c < NCH; c++) begin
            for (int se = 8*n - 38; se <= 8*n - 31; se++) begin
                if (!ev && gr(se) == polm && gr(se-1) != polm) begin
                    for (int t = se - sum; t < se + hom; t++) begin
                        int r;
                        r = t + clampi(skm[c]);
                        if (!ev && gd(c, r) != gd(c, r-1)) begin
                            ev = 1'b1; ec = c; eo = t - se;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check_word(input string tag, input int n);
        bit ev; int ec, eo;
        model(n, ev, ec, eo);
        n_chk++;
        if (v !== ev || (ev && (int'(ch) != ec || int'(off) != eo))
            || (!ev && (ch !== 2'd0 || off !== 7'sd0))) begin
            n_fail++;
            $display("FAIL %s word %0d: got v=%0d ch=%0d off=%0d, expected v=%0d ch=%0d off=%0d",
                     tag, n, v, ch, off, ev, ec, eo);
        end
    endtask

    task automatic check_idle(input string tag);
        n_chk++;
        if (v !== 1'b0 || ch !== 2'd0 || off !== 7'sd0) begin
            n_fail++;
            $display("FAIL %s: got v=%0d ch=%0d off=%0d, expected v=0 ch=0 off=0",
                     tag, v, ch, off);
        end
    endtask

    task automatic clear_stim();
        for (int c = 0; c < NCH; c++) begin
            skm[c] = 0;
            for (int i = 0; i < NS; i++) dm[c][i] = 1'b0;
        end
        for (int i = 0; i < NS; i++) rm[i] = 1'b0;
        sum = 4; hom = 2; polm = 1'b1;
    endtask

    task automatic toggle(input int c, input int at);
        for (int i = at; i < NS; i++) dm[c][i] = ~dm[c][i];
    endtask

    task automatic clk_hi(input int from, input int upto);
        for (int i = from; i < upto; i++) rm[i] = 1'b1;
    endtask

    task automatic drive(input int n);
        for (int c = 0; c < NCH; c++)
            for (int j = 0; j < SPW; j++) dat[c*SPW+j] = gd(c, n*SPW + j);
        for (int j = 0; j < SPW; j++) refw[j] = gr(n*SPW + j);
    endtask

    // Reset, stream all words and compare every output cycle.
    task automatic run_scn(input string tag);
        for (int c = 0; c < NCH; c++) skew[c*5 +: 5] = 5'(skm[c]);
        setup = 5'(sum);
        hold  = 5'(hom);
        rise  = polm;
        @(negedge clk);
        rst_n = 1'b0;
        dat = '0;
        refw = '0;
        repeat (2) @(posedge clk);
        for (int n = 0; n <= NWR; n++) begin
            @(negedge clk);
            rst_n = 1'b1;
            drive(n);
            @(posedge clk);
            #1;
            if (n >= 1) check_word(tag, n - 1);
        end
    endtask

    task automatic periodic_stim();
        clear_stim();
        for (int i = 0; i < 400; i++) begin
            rm[i] = (i % 12) < 6;
            for (int c = 0; c < NCH; c++) dm[c][i] = (((i + 3*c) / (5 + c)) % 2) == 1;
        end
        skm[0] = 1; skm[1] = -3; skm[2] = 0; skm[3] = 5;
        sum = 3; hom = 2;
    endtask

    task automatic t_setup_hold();
        clear_stim();
        sum = 4; hom = 2;
        clk_hi(100, 120);
        toggle(1, 97);
        toggle(2, 50);
        toggle(3, 101);
        clk_hi(200, 220);
        toggle(3, 201);
        toggle(0, 202);
        run_scn("R2/R4/R6/R8 setup-hold");
    endtask

    task automatic t_bounds();
        clear_stim();
        sum = 5; hom = 3;
        clk_hi(100, 120); clk_hi(200, 220); clk_hi(300, 320); clk_hi(400, 420);
        toggle(0, 95);
        toggle(1, 194);
        toggle(2, 302);
        toggle(3, 403);
        toggle(0, 400);
        run_scn("R4 window bounds");
    endtask

    task automatic t_skew();
        clear_stim();
        sum = 2; hom = 2;
        skm[0] = 3; skm[1] = -2; skm[2] = 15; skm[3] = -16;
        clk_hi(100, 120); clk_hi(200, 220); clk_hi(300, 320); clk_hi(400, 420);
        toggle(0, 103);
        toggle(1, 197);
        toggle(1, 101);
        toggle(2, 309);
        toggle(3, 392);
        run_scn("R3 skew");
    endtask

    task automatic t_polarity();
        clear_stim();
        polm = 1'b0; sum = 3; hom = 3;
        clk_hi(100, 120);
        toggle(1, 100);
        toggle(2, 121);
        clk_hi(200, 204);
        toggle(0, 201);
        run_scn("R2/R8 falling edge");
    endtask

    task automatic t_priority();
        clear_stim();
        sum = 2; hom = 2;
        clk_hi(99, 101);
        clk_hi(103, 111);
        toggle(2, 98); toggle(2, 100); toggle(2, 102);
        toggle(3, 99);
        run_scn("R7 priority");
    endtask

    task automatic t_periodic();
        periodic_stim();
        run_scn("R1/R5/R6 periodic");
        periodic_stim();
        sum = 0; hom = 0;
        run_scn("R4 empty window");
    endtask

    task automatic t_reset();
        periodic_stim();
        run_scn("R9 pre-reset run");
        @(negedge clk);
        rst_n = 1'b0;
        dat = '0;
        refw = '0;
        @(posedge clk);
        #1;
        check_idle("R9 outputs in reset");
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            rst_n = 1'b1;
            dat = '0;
            refw = '0;
            @(posedge clk);
            #1;
            check_idle("R9 history cleared");
        end
    endtask

    initial begin
        clear_stim();
        repeat (2) @(posedge clk);
        #1;
        check_idle("R9 reset state");
        t_setup_hold();
        t_bounds();
        t_skew();
        t_polarity();
        t_priority();
        t_periodic();
        t_reset();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule